// File: doc/BRIEF.md
# Store-Data Forwarding and Load-Use Stall Control

This block is the hazard control for a five-stage in-order pipeline. It has two jobs. The first is to route a recent result onto the data operand of a store, at whichever stage that store has reached. The second is to freeze the front of the pipeline for one cycle when a load's result is needed by the instruction directly behind it. The block is purely combinational. It reads register numbers and a few control flags from the four pipeline registers and produces mux selects, write enables and a bubble request within the same cycle.

For a store in the execute stage, the data operand can come from three places: the register-file read, the older writeback result, or the newer ALU result waiting in the memory stage. The newer value wins. A load sitting in the memory stage has no data yet. Such a store therefore takes no forward in execute and picks up the loaded value one cycle later, at the memory stage's write port. For this reason a load followed by a store of the loaded register never stalls. A stall happens only when the loaded register feeds an address base or an ALU source of the instruction in decode.

Top module: `store_hazard_ctrl`

## Requirements
- R1: `mem_store_fwd` is 1 exactly when `mem_is_store`=1, `wb_wr_reg`=1, `wb_rd` equals `mem_rt` and `wb_rd` is nonzero. Otherwise it is 0.
- R2: When `ex_is_store`=1, `wb_wr_reg`=1, `wb_rd` equals `ex_rt`, `wb_rd` is nonzero, and neither R3 nor R4 applies, `ex_store_sel` is 2'b01 (writeback result).
- R3: When `ex_is_store`=1, `mem_wr_reg`=1, `mem_is_load`=0, `mem_rd` equals `ex_rt` and `mem_rd` is nonzero, `ex_store_sel` is 2'b10 (memory-stage ALU result). This holds even if the writeback stage also matches.
- R4: When `ex_is_store`=1 and the memory stage holds a load (`mem_is_load`=1, `mem_wr_reg`=1) whose nonzero `mem_rd` equals `ex_rt`, `ex_store_sel` is 2'b00 (register file), even if the writeback stage matches.
- R5: With `ex_is_load`=1 and a nonzero `ex_rt` equal to `id_rs`, a stall is requested, whatever `id_is_store` is.
- R6: With `ex_is_load`=1, a nonzero `ex_rt` equal to `id_rt`, `id_rt_read`=1 and `id_is_store`=0, a stall is requested. With `id_rt_read`=0, a match on `id_rt` alone requests no stall.
- R7: When the decode instruction is a store (`id_is_store`=1) and only its data register `id_rt` matches the load in execute, no stall is requested.
- R8: A stall drives `pc_wr_en`=0, `ifid_wr_en`=0 and `idex_bubble`=1. Without a stall these are 1, 1 and 0.
- R9: Register 0 never causes a forward or a stall.
- R10: When `ex_is_store`=0, `ex_store_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | Decode-stage first source register (address base for loads and stores) |
| id_rt | input | 5 | Decode-stage second register field |
| id_rt_read | input | 1 | Decode instruction reads `id_rt` as a source |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rt | input | 5 | Execute-stage rt field: load destination or store data register |
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| ex_is_store | input | 1 | Execute-stage instruction writes memory |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_rt | input | 5 | Memory-stage store data register |
| mem_wr_reg | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction reads memory |
| mem_is_store | input | 1 | Memory-stage instruction writes memory |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_wr_reg | input | 1 | Writeback-stage instruction writes a register |
| ex_store_sel | output | 2 | Store-data select in execute: 00 register file, 01 writeback, 10 memory stage |
| mem_store_fwd | output | 1 | Replace the memory write data with the writeback result |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero all control bits entering the execute stage |

## Verification
A table of directed patterns covers each forwarding source on its own. It then covers the three-way contention in which writeback and memory both match a store in execute, once with an ALU producer and once with a load producer in the memory stage, which separates R3 from R4. The stall cases put the loaded register into the base field, into an ALU rt source, into a store's data field only, and into an rt field that is not read, which separates a real dependency from a harmless field match. Register-0 patterns confirm that a zero index suppresses both matching paths. A long sweep over a narrow register range then forces frequent coincidental matches and compares every output against a reference model written from the requirements.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned REG_AW = 5;
  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_WB    = 2'b01,
    SEL_EXMEM = 2'b10
  } store_sel_e;

  // a producer is usable only if it writes a real (nonzero) register
  function automatic logic live_hit(input logic wr, input reg_idx_t dst, input reg_idx_t src);
    return wr && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_store_fwd_mem.sv
module hz_store_fwd_mem
  import hz_pkg::*;
(
  input  logic     mem_is_store,
  input  reg_idx_t mem_rt,
  input  logic     wb_wr_reg,
  input  reg_idx_t wb_rd,
  output logic     fwd
);
  assign fwd = mem_is_store && live_hit(wb_wr_reg, wb_rd, mem_rt);

  always_comb begin
    p_no_zero_fwd_r9: assert (!(fwd && (wb_rd == '0)))
      else $error("zero register forwarded to memory write port");
    p_fwd_needs_store_r1: assert (!fwd || (mem_is_store && wb_wr_reg))
      else $error("memory forward without store and writer");
  end
endmodule

// File: rtl/hz_store_fwd_ex.sv
module hz_store_fwd_ex
  import hz_pkg::*;
#(
  parameter bit USE_EXMEM_PATH = 1'b1
) (
  input  logic       ex_is_store,
  input  reg_idx_t   ex_rt,
  input  logic       mem_wr_reg,
  input  logic       mem_is_load,
  input  reg_idx_t   mem_rd,
  input  logic       wb_wr_reg,
  input  reg_idx_t   wb_rd,
  output store_sel_e sel
);
  logic mem_match;
  logic mem_ready;
  logic wb_match;

  assign wb_match = live_hit(wb_wr_reg, wb_rd, ex_rt);

  generate
    if (USE_EXMEM_PATH) begin : g_exmem
      assign mem_match = live_hit(mem_wr_reg, mem_rd, ex_rt);
      assign mem_ready = !mem_is_load;
    end else begin : g_no_exmem
      assign mem_match = 1'b0;
      assign mem_ready = 1'b0;
    end
  endgenerate

  always_comb begin
    sel = SEL_RF;
    if (ex_is_store) begin
      if (mem_match) begin
        // newer producer shadows the older one; a pending load is not ready
        sel = mem_ready ? SEL_EXMEM : SEL_RF;
      end else if (wb_match) begin
        sel = SEL_WB;
      end
    end
  end

  always_comb begin
    p_sel_legal_r2: assert (sel != 2'b11) else $error("illegal store select");
    p_idle_no_fwd_r10: assert (ex_is_store || sel == SEL_RF)
      else $error("forward selected without a store");
    p_no_load_src_r4: assert (!(sel == SEL_EXMEM && mem_is_load))
      else $error("forwarded from a load that has no data yet");
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter bit STORE_DATA_EXEMPT = 1'b1
) (
  input  reg_idx_t id_rs,
  input  reg_idx_t id_rt,
  input  logic     id_rt_read,
  input  logic     id_is_store,
  input  logic     ex_is_load,
  input  reg_idx_t ex_rt,
  output logic     stall
);
  logic base_dep;
  logic rt_dep;

  assign base_dep = live_hit(ex_is_load, ex_rt, id_rs);

  generate
    if (STORE_DATA_EXEMPT) begin : g_exempt
      assign rt_dep = id_rt_read && !id_is_store && live_hit(ex_is_load, ex_rt, id_rt);
    end else begin : g_plain
      assign rt_dep = id_rt_read && live_hit(ex_is_load, ex_rt, id_rt);
    end
  endgenerate

  assign stall = base_dep || rt_dep;

  always_comb begin
    p_stall_src_load_r5: assert (!stall || ex_is_load)
      else $error("stall without a load in execute");
    p_stall_zero_r9: assert (!(stall && ex_rt == '0))
      else $error("stall on register zero");
  end
endmodule

// File: rtl/store_hazard_ctrl.sv
module store_hazard_ctrl
  import hz_pkg::*;
(
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rt_read,
  input  logic              id_is_store,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              ex_is_load,
  input  logic              ex_is_store,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic [REG_AW-1:0] mem_rt,
  input  logic              mem_wr_reg,
  input  logic              mem_is_load,
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr_reg,
  output logic [1:0]        ex_store_sel,
  output logic              mem_store_fwd,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              idex_bubble
);
  store_sel_e sel_ex;
  logic       stall;

  hz_store_fwd_ex #(.USE_EXMEM_PATH(1'b1)) u_fwd_ex (
    .ex_is_store (ex_is_store),
    .ex_rt       (ex_rt),
    .mem_wr_reg  (mem_wr_reg),
    .mem_is_load (mem_is_load),
    .mem_rd      (mem_rd),
    .wb_wr_reg   (wb_wr_reg),
    .wb_rd       (wb_rd),
    .sel         (sel_ex)
  );

  hz_store_fwd_mem u_fwd_mem (
    .mem_is_store (mem_is_store),
    .mem_rt       (mem_rt),
    .wb_wr_reg    (wb_wr_reg),
    .wb_rd        (wb_rd),
    .fwd          (mem_store_fwd)
  );

  hz_load_use #(.STORE_DATA_EXEMPT(1'b1)) u_load_use (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_rt_read  (id_rt_read),
    .id_is_store (id_is_store),
    .ex_is_load  (ex_is_load),
    .ex_rt       (ex_rt),
    .stall       (stall)
  );

  assign ex_store_sel = sel_ex;
  assign pc_wr_en     = !stall;
  assign ifid_wr_en   = !stall;
  assign idex_bubble  = stall;

  always_comb begin
    p_bubble_holds_r8: assert ((idex_bubble == !pc_wr_en) && (idex_bubble == !ifid_wr_en))
      else $error("bubble and front-end hold disagree");
  end
endmodule

// File: tb/store_hazard_ctrl_bench.sv
module store_hazard_ctrl_bench;
  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt; logic rtrd; logic st;
    logic [4:0] exrt; logic exld; logic exst;
    logic [4:0] mrd; logic [4:0] mrt; logic mwr; logic mld; logic mst;
    logic [4:0] wbrd; logic wbwr;
    logic [1:0] esel; logic emf; logic estall;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'd1,5'd2,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,5'd5,1'b0,1'b0,1'b1, 5'd5,1'b1, 2'b00,1'b1,1'b0, 8'd1}, // R1 hit
    '{5'd1,5'd2,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,5'd5,1'b0,1'b0,1'b1, 5'd5,1'b0, 2'b00,1'b0,1'b0, 8'd1}, // R1 no writer
    '{5'd1,5'd2,1'b0,1'b0, 5'd7,1'b0,1'b1, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd7,1'b1, 2'b01,1'b0,1'b0, 8'd2}, // R2
    '{5'd1,5'd2,1'b0,1'b0, 5'd7,1'b0,1'b1, 5'd7,5'd0,1'b1,1'b0,1'b0, 5'd7,1'b1, 2'b10,1'b0,1'b0, 8'd3}, // R3 priority
    '{5'd1,5'd2,1'b0,1'b0, 5'd7,1'b0,1'b1, 5'd7,5'd0,1'b1,1'b1,1'b0, 5'd7,1'b1, 2'b00,1'b0,1'b0, 8'd4}, // R4 load shadow
    '{5'd3,5'd4,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b1, 8'd5}, // R5 base
    '{5'd1,5'd4,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b1, 8'd6}, // R6 alu rt
    '{5'd1,5'd4,1'b1,1'b1, 5'd4,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b0, 8'd7}, // R7 store data
    '{5'd1,5'd4,1'b0,1'b0, 5'd4,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b0, 8'd6}, // R6 rt unread
    '{5'd0,5'd0,1'b1,1'b0, 5'd0,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b0, 8'd9}, // R9 load r0
    '{5'd1,5'd2,1'b0,1'b0, 5'd0,1'b0,1'b1, 5'd0,5'd0,1'b1,1'b0,1'b1, 5'd0,1'b1, 2'b00,1'b0,1'b0, 8'd9}, // R9 fwd r0
    '{5'd1,5'd2,1'b0,1'b0, 5'd7,1'b0,1'b0, 5'd7,5'd0,1'b1,1'b0,1'b0, 5'd7,1'b1, 2'b00,1'b0,1'b0, 8'd10},// R10
    '{5'd4,5'd4,1'b1,1'b1, 5'd4,1'b1,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,1'b0, 2'b00,1'b0,1'b1, 8'd5}  // R5 store base
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex_rt, mem_rd, mem_rt, wb_rd;
  logic id_rt_read, id_is_store, ex_is_load, ex_is_store;
  logic mem_wr_reg, mem_is_load, mem_is_store, wb_wr_reg;
  logic [1:0] ex_store_sel;
  logic mem_store_fwd, pc_wr_en, ifid_wr_en, idex_bubble;

  store_hazard_ctrl u_store_hazard_ctrl (
    .id_rs(id_rs), .id_rt(id_rt), .id_rt_read(id_rt_read), .id_is_store(id_is_store),
    .ex_rt(ex_rt), .ex_is_load(ex_is_load), .ex_is_store(ex_is_store),
    .mem_rd(mem_rd), .mem_rt(mem_rt), .mem_wr_reg(mem_wr_reg),
    .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .wb_rd(wb_rd), .wb_wr_reg(wb_wr_reg),
    .ex_store_sel(ex_store_sel), .mem_store_fwd(mem_store_fwd),
    .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .idex_bubble(idex_bubble)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    #1;
    id_rs = v.rs; id_rt = v.rt; id_rt_read = v.rtrd; id_is_store = v.st;
    ex_rt = v.exrt; ex_is_load = v.exld; ex_is_store = v.exst;
    mem_rd = v.mrd; mem_rt = v.mrt; mem_wr_reg = v.mwr; mem_is_load = v.mld; mem_is_store = v.mst;
    wb_rd = v.wbrd; wb_wr_reg = v.wbwr;
    @(negedge clk);
  endtask

  // reference model written from the requirements
  function automatic vec_t model(input vec_t v);
    vec_t r = v;
    logic mhit, whit;
    mhit = v.mwr && v.mrd != 0 && v.mrd == v.exrt;
    whit = v.wbwr && v.wbrd != 0 && v.wbrd == v.exrt;
    r.esel = !v.exst ? 2'b00 : mhit ? (v.mld ? 2'b00 : 2'b10) : whit ? 2'b01 : 2'b00;
    r.emf = v.mst && v.wbwr && v.wbrd != 0 && v.wbrd == v.mrt;
    r.estall = v.exld && v.exrt != 0 &&
               (v.exrt == v.rs || (v.rtrd && !v.st && v.exrt == v.rt));
    return r;
  endfunction

  task automatic check_all(input vec_t v, input string tag);
    chk({tag, " sel"}, {2'b00, ex_store_sel}, {2'b00, v.esel});
    chk({tag, " memfwd"}, {3'b000, mem_store_fwd}, {3'b000, v.emf});
    chk({tag, " stall R8"}, {1'b0, pc_wr_en, ifid_wr_en, idex_bubble},
        {1'b0, !v.estall, !v.estall, v.estall});
  endtask

  initial begin
    vec_t z;
    z = '0;
    id_rs = 0; id_rt = 0; id_rt_read = 0; id_is_store = 0; ex_rt = 0; ex_is_load = 0;
    ex_is_store = 0; mem_rd = 0; mem_rt = 0; mem_wr_reg = 0; mem_is_load = 0;
    mem_is_store = 0; wb_rd = 0; wb_wr_reg = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // quiescent state: no forward, no stall (R8, R10)
    check_all(z, "reset R8 R10");

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_all(VECS[i], $sformatf("table%0d R%0d", i, VECS[i].req));
    end

    // sweep over a narrow register range to force coincidental matches
    for (int k = 0; k < 4000; k++) begin
      vec_t v;
      v = '0;
      v.rs = 5'($urandom_range(0, 3)); v.rt = 5'($urandom_range(0, 3));
      v.rtrd = 1'($urandom); v.st = 1'($urandom);
      v.exrt = 5'($urandom_range(0, 3)); v.exld = 1'($urandom); v.exst = 1'($urandom);
      v.mrd = 5'($urandom_range(0, 3)); v.mrt = 5'($urandom_range(0, 3));
      v.mwr = 1'($urandom); v.mld = 1'($urandom); v.mst = 1'($urandom);
      v.wbrd = 5'($urandom_range(0, 3)); v.wbwr = 1'($urandom);
      v = model(v);
      apply(v);
      check_all(v, "sweep R1 R2 R3 R4 R5 R6 R7 R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule